// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits beside a byte-wide flash array and decodes the stream of bus write cycles into array commands. A data-altering command is accepted only after a fixed address/data handshake. Program needs three handshake writes before the data write. Erase needs six writes in total. A write that does not fit the expected next step sends the sequence back to its idle (read) state. An accepted command produces a one-cycle launch pulse, together with an operation code and the captured target address and data, for the array controller to act on.

The same handshake also switches the device into and out of an identification mode. In that mode the read-data path returns a manufacturer code or a device code, selected by the lowest address bit. The array controller drives a busy input while it works; write cycles that arrive during busy are dropped. A parallel-mode input gates the whole-chip erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset (rst_ni low, asynchronous) launch_o is 0, id_mode_o is 0 and id_data_o is 00h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then D@T make launch_o high in the cycle after the edge that accepts the fourth write. In that cycle op_o is 0 (program), tgt_addr_o is T at full width and tgt_data_o is D. The target outputs hold until the next launch.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@S launch with op_o = 1 (sector erase) and tgt_addr_o = S.
- R4: The same five-write lead-in followed by 50h@B launches with op_o = 2 (block erase) and tgt_addr_o = B.
- R5: The same lead-in followed by 10h@5555h launches with op_o = 3 (chip erase) only while par_mode_i is 1. With par_mode_i at 0 the write aborts and there is no launch.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set id_mode_o. While id_mode_o is 1, id_data_o is BFh when addr_i[0] is 0 and 5Ah when it is 1. Otherwise id_data_o is 00h. id_data_o is combinational from addr_i.
- R7: ID mode is cleared by a single F0h write to any address from idle, or by AAh@5555h, 55h@2AAAh, F0h@5555h. id_mode_o changes only in the cycle after an accepted write.
- R8: A write that does not match the expected next step returns the sequence to idle. The remaining steps then cause no launch, and id_mode_o is left unchanged.
- R9: Only addr_i[14:0] is compared against 5555h/2AAAh. The upper address bits do not affect decoding.
- R10: A write with busy_i high is ignored. The sequence position and id_mode_o are unchanged, and no launch follows.
- R11: launch_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | ADDR_W (20) | Bus address |
| wdata_i | input | 8 | Write data |
| busy_i | input | 1 | Array operation in progress; writes dropped |
| par_mode_i | input | 1 | Parallel mode; enables chip erase |
| launch_o | output | 1 | One-cycle command launch pulse |
| op_o | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| tgt_addr_o | output | ADDR_W (20) | Captured target address |
| tgt_data_o | output | 8 | Captured program data |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 8 | Identification read data |

## Verification
A launch, its operation code and its target fields appear one cycle after the clock edge that accepts the final write. id_mode_o also follows one cycle after its write. id_data_o follows addr_i within the same cycle. The bench drives every input on the falling edge. A monitor samples launch_o on the falling edge that follows each rising edge, so it sees each launch exactly in its own cycle. It matches each launch against the queue of expected commands and flags any second high cycle. Identification reads are checked one nanosecond after the address is driven. Aborted, busy and non-parallel sequences are checked by comparing launch counts before and after the sequence, and by confirming that the expected queue ends empty.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMP_W     = 15;
  localparam int NUM_CODES = 9;

  localparam int C_AA = 0;
  localparam int C_55 = 1;
  localparam int C_A0 = 2;
  localparam int C_80 = 3;
  localparam int C_30 = 4;
  localparam int C_50 = 5;
  localparam int C_10 = 6;
  localparam int C_90 = 7;
  localparam int C_F0 = 8;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]       MFR_CODE   = 8'hBF;
  localparam logic [7:0]       DEV_CODE   = 8'h5A;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERA3, ST_ERA4, ST_ERA5
  } seq_st_e;

  function automatic logic [7:0] code_val(input int idx);
    case (idx)
      C_AA:    return 8'hAA;
      C_55:    return 8'h55;
      C_A0:    return 8'hA0;
      C_80:    return 8'h80;
      C_30:    return 8'h30;
      C_50:    return 8'h50;
      C_10:    return 8'h10;
      C_90:    return 8'h90;
      default: return 8'hF0;
    endcase
  endfunction
endpackage

// File: rtl/cmd_step_match.sv
module cmd_step_match
  import flash_cmd_pkg::*;
(
  input  logic [CMP_W-1:0]     addr_i,
  input  logic [7:0]           data_i,
  output logic                 at_a_o,
  output logic                 at_b_o,
  output logic [NUM_CODES-1:0] hit_o
);
  assign at_a_o = (addr_i == KEY_ADDR_A);
  assign at_b_o = (addr_i == KEY_ADDR_B);

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    assign hit_o[g] = (data_i == code_val(g));
  end
endmodule

// File: rtl/id_code_rom.sv
module id_code_rom
  import flash_cmd_pkg::*;
(
  input  logic       id_mode_i,
  input  logic       sel_i,
  output logic [7:0] code_o
);
  always_comb begin
    if (!id_mode_i) code_o = 8'h00;
    else            code_o = sel_i ? DEV_CODE : MFR_CODE;
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 busy_i,
  input  logic                 par_mode_i,
  input  logic                 at_a_i,
  input  logic                 at_b_i,
  input  logic [NUM_CODES-1:0] hit_i,
  output logic                 capture_o,
  output logic                 launch_o,
  output op_e                  op_o,
  output logic                 id_mode_o
);
  seq_st_e st_q, st_d;
  op_e     op_q, op_d;
  logic    id_q, id_d, fire, launch_q;
  logic    evt;

  assign evt = wr_i && !busy_i;

  always_comb begin
    st_d = st_q;
    op_d = op_q;
    id_d = id_q;
    fire = 1'b0;
    if (evt) begin
      case (st_q)
        ST_IDLE: begin
          if (at_a_i && hit_i[C_AA])   st_d = ST_UNL1;
          else if (id_q && hit_i[C_F0]) id_d = 1'b0;
        end
        ST_UNL1: st_d = (at_b_i && hit_i[C_55]) ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          st_d = ST_IDLE;
          if (at_a_i) begin
            if (hit_i[C_A0])      st_d = ST_PROG;
            else if (hit_i[C_80]) st_d = ST_ERA3;
            else if (hit_i[C_90]) id_d = 1'b1;
            else if (hit_i[C_F0]) id_d = 1'b0;
          end
        end
        ST_PROG: begin
          st_d = ST_IDLE;
          fire = 1'b1;
          op_d = OP_PROG;
        end
        ST_ERA3: st_d = (at_a_i && hit_i[C_AA]) ? ST_ERA4 : ST_IDLE;
        ST_ERA4: st_d = (at_b_i && hit_i[C_55]) ? ST_ERA5 : ST_IDLE;
        ST_ERA5: begin
          st_d = ST_IDLE;
          if (hit_i[C_30]) begin
            fire = 1'b1; op_d = OP_SECT;
          end else if (hit_i[C_50]) begin
            fire = 1'b1; op_d = OP_BLOCK;
          end else if (hit_i[C_10] && at_a_i && par_mode_i) begin
            fire = 1'b1; op_d = OP_CHIP;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_PROG;
      id_q     <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      id_q     <= id_d;
      launch_q <= fire;
    end
  end

  assign capture_o = fire;
  assign launch_o  = launch_q;
  assign op_o      = op_q;
  assign id_mode_o = id_q;

  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> (st_q == $past(st_q)) && $stable(id_mode_o) && !launch_o);
  assert_chip_par_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && op_o == OP_CHIP) |-> $past(par_mode_i));
  assert_launch_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> $past(wr_i && !busy_i));
  assert_id_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(id_mode_o));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  input  logic              par_mode_i,
  output logic              launch_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        tgt_data_o,
  output logic              id_mode_o,
  output logic [7:0]        id_data_o
);
  logic                 at_a, at_b, capture;
  logic [NUM_CODES-1:0] hit;
  op_e                  op;
  logic [ADDR_W-1:0]    tgt_addr_q;
  logic [7:0]           tgt_data_q;

  cmd_step_match u_match (
    .addr_i (addr_i[CMP_W-1:0]),
    .data_i (wdata_i),
    .at_a_o (at_a),
    .at_b_o (at_b),
    .hit_o  (hit)
  );

  cmd_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .busy_i     (busy_i),
    .par_mode_i (par_mode_i),
    .at_a_i     (at_a),
    .at_b_i     (at_b),
    .hit_i      (hit),
    .capture_o  (capture),
    .launch_o   (launch_o),
    .op_o       (op),
    .id_mode_o  (id_mode_o)
  );

  id_code_rom u_rom (
    .id_mode_i (id_mode_o),
    .sel_i     (addr_i[0]),
    .code_o    (id_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (capture) begin
      tgt_addr_q <= addr_i;
      tgt_data_q <= wdata_i;
    end
  end

  assign op_o       = op;
  assign tgt_addr_o = tgt_addr_q;
  assign tgt_data_o = tgt_data_q;

  assert_tgt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tgt_addr_o) |-> launch_o);
endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] addr;
    logic [7:0]  data;
  } exp_t;

  logic        clk = 0, rst_n = 0, wr = 0, busy = 0, par = 0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        launch, id_mode;
  logic [1:0]  op;
  logic [19:0] tgt_addr;
  logic [7:0]  tgt_data, id_data;

  int tests = 0, fails = 0, launches = 0;
  exp_t  expq[$];
  string tagq[$];
  logic  prev_launch = 0;

  always #4 clk = ~clk;

  flash_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .busy_i(busy), .par_mode_i(par), .launch_o(launch), .op_o(op),
    .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data), .id_mode_o(id_mode),
    .id_data_o(id_data)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic [19:0] a, input logic [7:0] d, input logic b = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; busy = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock(input logic [4:0] up = 5'h0);
    wr_cyc({up, 15'h5555}, 8'hAA);
    wr_cyc({up, 15'h2AAA}, 8'h55);
  endtask

  task automatic expect_cmd(input logic [1:0] o, input logic [19:0] a, input logic [7:0] d, input string tag);
    expq.push_back('{op: o, addr: a, data: d});
    tagq.push_back(tag);
  endtask

  task automatic id_read(input logic [19:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1 chk(id_data == exp, tag, id_data, exp);
  endtask

  // monitor: launch visible on the falling edge after the accepting rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (launch) begin
        launches++;
        chk(!prev_launch, "R11 launch repeated", 1, 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected launch", op, 0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(op == e.op, {t, " op"}, op, e.op);
          chk(tgt_addr == e.addr, {t, " addr"}, tgt_addr, e.addr);
          chk(tgt_data == e.data || e.op != 2'd0, {t, " data"}, tgt_data, e.data);
        end
      end
      prev_launch = launch;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    #1;
    chk(launch == 0, "R1 launch", launch, 0);
    chk(id_mode == 0, "R1 id_mode", id_mode, 0);
    chk(id_data == 8'h00, "R1 id_data", id_data, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R2 program
    unlock();
    wr_cyc(20'h05555, 8'hA0);
    expect_cmd(2'd0, 20'h12345, 8'h3C, "R2 program");
    wr_cyc(20'h12345, 8'h3C);
    repeat (2) @(negedge clk);
    chk(tgt_addr == 20'h12345, "R2 target hold", tgt_addr, 20'h12345);

    // R9 upper bits ignored
    unlock(5'h1F);
    wr_cyc(20'hA5555, 8'hA0);
    expect_cmd(2'd0, 20'hABCDE, 8'hA5, "R9 program upper bits");
    wr_cyc(20'hABCDE, 8'hA5);

    // R3 sector erase
    unlock(); wr_cyc(20'h05555, 8'h80); unlock();
    expect_cmd(2'd1, 20'h34000, 8'h00, "R3 sector erase");
    wr_cyc(20'h34000, 8'h30);

    // R4 block erase
    unlock(); wr_cyc(20'h05555, 8'h80); unlock(5'h3);
    expect_cmd(2'd2, 20'h70000, 8'h00, "R4 block erase");
    wr_cyc(20'h70000, 8'h50);

    // R5 chip erase
    par = 1;
    unlock(); wr_cyc(20'h05555, 8'h80); unlock();
    expect_cmd(2'd3, 20'h05555, 8'h00, "R5 chip erase");
    wr_cyc(20'h05555, 8'h10);
    par = 0;
    repeat (2) @(negedge clk);
    base = launches;
    unlock(); wr_cyc(20'h05555, 8'h80); unlock();
    wr_cyc(20'h05555, 8'h10);
    repeat (2) @(negedge clk);
    chk(launches == base, "R5 chip erase without par_mode", launches - base, 0);

    // R6 ID entry
    unlock(); wr_cyc(20'h05555, 8'h90);
    chk(id_mode == 1, "R6 id entry", id_mode, 1);
    id_read(20'h00000, 8'hBF, "R6 mfr code");
    id_read(20'h00001, 8'h5A, "R6 dev code");

    // R8 abort keeps id mode
    wr_cyc(20'h05555, 8'hAA);
    wr_cyc(20'h02AAA, 8'h77);
    chk(id_mode == 1, "R8 abort keeps id", id_mode, 1);

    // R10 busy write of F0 ignored
    wr_cyc(20'h00000, 8'hF0, 1'b1);
    chk(id_mode == 1, "R10 busy F0 ignored", id_mode, 1);

    // R7 single-cycle exit
    wr_cyc(20'h0BEEF, 8'hF0);
    chk(id_mode == 0, "R7 single exit", id_mode, 0);
    id_read(20'h00000, 8'h00, "R6 id_data outside id");

    // R7 prefixed exit
    unlock(); wr_cyc(20'h05555, 8'h90);
    chk(id_mode == 1, "R7 reenter", id_mode, 1);
    unlock(); wr_cyc(20'h05555, 8'hF0);
    chk(id_mode == 0, "R7 prefixed exit", id_mode, 0);

    // R8 mismatch aborts program
    base = launches;
    wr_cyc(20'h05555, 8'hAA);
    wr_cyc(20'h02AAB, 8'h55);
    wr_cyc(20'h05555, 8'hA0);
    wr_cyc(20'h01000, 8'h11);
    repeat (2) @(negedge clk);
    chk(launches == base, "R8 mismatch no launch", launches - base, 0);

    // R10 busy write holds sequence position
    unlock();
    wr_cyc(20'h05555, 8'h80, 1'b1);
    wr_cyc(20'h05555, 8'hA0);
    expect_cmd(2'd0, 20'h00042, 8'h99, "R10 busy hold program");
    wr_cyc(20'h00042, 8'h99);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2 R3 R4 R10 pending launches", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule